// File: doc/BRIEF.md
# Hardware Store Request Controller

This block sits in front of a memory that keeps a volatile SRAM array alongside a nonvolatile shadow copy. It watches an active-low store request pin driven from outside the chip. Once that pin has been seen low for long enough to count as a real request, the controller signals busy at once. It gives an SRAM cycle that is already under way a bounded number of cycles to finish. After that it decides whether a copy into the nonvolatile array is needed. The copy is started only when the SRAM has been written since the last store or recall completed. Otherwise the request just parks the device.

Either way the device then stays inhibited: no SRAM access is granted until the request pin has gone high again. If a store is running, the inhibit also lasts until the store engine reports completion. A fixed recovery interval follows. The nonvolatile engine is outside this block. It receives a one-cycle start pulse and answers with a one-cycle done pulse, so the long programming time can be shortened freely in simulation. A separate done pulse from the recall path also clears the written flag.

All durations are parameters counted in clock cycles. These are the synchronizer depth, the minimum low time of the request, the drain window for an SRAM cycle in progress, the recovery interval, and the worst-case busy latency that elaboration checks the others against.

Top module: `nvsram_hw_store_ctrl`

## Requirements
- R1: In and right after reset, `busy_n` is 1, `sram_grant` is 1 and `nv_store_go` is 0.
- R2: A low pulse on `store_req_n` seen for fewer than MIN_LOW_CYCLES consecutive clock edges is ignored: `busy_n` and `sram_grant` stay 1.
- R3: A low level held for MIN_LOW_CYCLES edges or more is recognised, and `busy_n` falls no more than BUSY_MAX_CYCLES clock cycles after the pin falls (SYNC_STAGES + MIN_LOW_CYCLES + 1 cycles with the defaults).
- R4: After recognition, `sram_grant` stays 1 only while an SRAM cycle is in progress (`sram_ce_n` = 0), for at most DRAIN_CYCLES cycles. A cycle that has already ended, or a new one, gets no grant.
- R5: A write is counted when `sram_ce_n` = 0 and `sram_we_n` = 0 at a clock edge while `sram_grant` is 1. If a write was counted since reset or since the last completed store or recall, the request produces exactly one `nv_store_go` pulse after the drain.
- R6: With no counted write since the last completed store or recall, a recognised request produces no `nv_store_go` pulse, yet the device is still inhibited as in R8.
- R7: While busy and past the drain, `sram_grant` is 0 and write strobes are not counted.
- R8: `busy_n` stays 0 and `sram_grant` stays 0 until the pin has returned high and any started store has reported `nv_store_done`. A further RECOVER_CYCLES cycles of inhibit then follow before both return to 1.
- R9: A `nv_recall_done` pulse clears the written flag. If a write strobe falls in the same cycle, the clear wins.
- R10: `nv_store_go` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| store_req_n | input | 1 | Active-low hardware store request pin (asynchronous) |
| sram_ce_n | input | 1 | Active-low SRAM chip enable from the host |
| sram_we_n | input | 1 | Active-low SRAM write enable from the host |
| nv_store_done | input | 1 | One-cycle completion pulse from the nonvolatile engine |
| nv_recall_done | input | 1 | One-cycle completion pulse of a recall |
| nv_store_go | output | 1 | One-cycle start pulse to the nonvolatile engine |
| busy_n | output | 1 | Active-low busy, low from recognition to end of recovery |
| sram_grant | output | 1 | High when an SRAM access may proceed |

## Verification
The hardest situation to reach is one where the pin is released while a store is still running. In that case the recovery count has to begin at the engine's done pulse and not at the pin edge. The bench gets there by giving its engine model a long latency and releasing the request shortly after busy falls. It also drives an SRAM cycle that outlasts the drain window, and it lands a write strobe in the same cycle as a recall completion. The random phase draws engine latency, hold time, pulse length and write or recall activity from a seeded generator. A bench-side written flag predicts whether each request must start a store.

// File: rtl/hsr_pkg.sv
package hsr_pkg;

   typedef enum logic [2:0] {
      HS_IDLE    = 3'd0,
      HS_DRAIN   = 3'd1,
      HS_DECIDE  = 3'd2,
      HS_STORING = 3'd3,
      HS_HOLD    = 3'd4,
      HS_RECOVER = 3'd5
   } hs_state_e;

   function automatic int hs_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/hsr_req_filter.sv
module hsr_req_filter #(
   parameter int SYNC_STAGES    = 2,
   parameter int MIN_LOW_CYCLES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   output logic pin_high,
   output logic req_seen
);

   logic [SYNC_STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[SYNC_STAGES-2:0], pin_n};
   end

   assign pin_high = chain_q[SYNC_STAGES-1];

   logic seen_q;

   generate
      if (MIN_LOW_CYCLES == 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) seen_q <= 1'b0;
            else        seen_q <= ~pin_high;
         end
      end else begin : g_count
         localparam int CW = $clog2(MIN_LOW_CYCLES + 1);
         localparam logic [CW-1:0] LAST = CW'(MIN_LOW_CYCLES - 1);
         logic [CW-1:0] run_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_q  <= '0;
               seen_q <= 1'b0;
            end else if (pin_high) begin
               run_q  <= '0;
               seen_q <= 1'b0;
            end else if (run_q == LAST) begin
               seen_q <= 1'b1;
            end else begin
               run_q  <= run_q + 1'b1;
            end
         end
      end
   endgenerate

   assign req_seen = seen_q;

   // R2 / R3: recognition only ever follows a low synchronized sample
   a_r3_seen_after_low: assert property (@(posedge clk) disable iff (!rst_n)
      req_seen |-> $past(!pin_high));

endmodule

// File: rtl/hsr_dirty.sv
module hsr_dirty (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_stb,
   input  logic clr,
   output logic dirty
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dirty <= 1'b0;
      else if (clr)    dirty <= 1'b0;
      else if (wr_stb) dirty <= 1'b1;
   end

   // R9: a completed store or recall leaves the flag clear, even against a write
   a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !dirty);

   // R5: a counted write without a clear marks the array as modified
   a_r5_write_marks: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && !clr) |=> dirty);

endmodule

// File: rtl/hsr_fsm.sv
module hsr_fsm
   import hsr_pkg::*;
#(
   parameter int DRAIN_CYCLES   = 4,
   parameter int RECOVER_CYCLES = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_seen,
   input  logic pin_high,
   input  logic cyc_active,
   input  logic dirty,
   input  logic nv_done,
   output logic busy_n,
   output logic grant,
   output logic store_go,
   output logic store_complete
);

   localparam int TMAX = hs_max(DRAIN_CYCLES, RECOVER_CYCLES);
   localparam int TW   = $clog2(TMAX + 1);
   localparam logic [TW-1:0] DRAIN_LAST   = TW'(DRAIN_CYCLES - 1);
   localparam logic [TW-1:0] RECOVER_LAST = TW'(RECOVER_CYCLES - 1);

   hs_state_e      st_q, st_d;
   logic [TW-1:0]  tmr_q, tmr_d;

   always_comb begin
      st_d  = st_q;
      tmr_d = tmr_q;
      unique case (st_q)
         HS_IDLE: begin
            tmr_d = '0;
            if (req_seen) st_d = HS_DRAIN;
         end
         HS_DRAIN: begin
            if (!cyc_active || tmr_q == DRAIN_LAST) st_d = HS_DECIDE;
            else                                    tmr_d = tmr_q + 1'b1;
         end
         HS_DECIDE: begin
            st_d = dirty ? HS_STORING : HS_HOLD;
         end
         HS_STORING: begin
            if (nv_done) st_d = HS_HOLD;
         end
         HS_HOLD: begin
            tmr_d = '0;
            if (pin_high) st_d = HS_RECOVER;
         end
         HS_RECOVER: begin
            if (tmr_q == RECOVER_LAST) st_d = HS_IDLE;
            else                       tmr_d = tmr_q + 1'b1;
         end
         default: st_d = HS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= HS_IDLE;
         tmr_q <= '0;
      end else begin
         st_q  <= st_d;
         tmr_q <= tmr_d;
      end
   end

   assign busy_n         = (st_q == HS_IDLE);
   assign grant          = (st_q == HS_IDLE) || (st_q == HS_DRAIN && cyc_active);
   assign store_go       = (st_q == HS_DECIDE) && dirty;
   assign store_complete = (st_q == HS_STORING) && nv_done;

   // R10: the start pulse lasts one cycle
   a_r10_go_single: assert property (@(posedge clk) disable iff (!rst_n)
      store_go |=> !store_go);

   // R4: while busy, a grant only covers a cycle still in progress
   a_r4_grant_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_n && grant) |-> cyc_active);

   // R8: inhibit persists while the synchronized pin is still low
   a_r8_hold_while_low: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == HS_HOLD && !pin_high) |=> (st_q == HS_HOLD));

   // R8: a running store keeps the device inhibited until the engine reports
   a_r8_store_waits: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == HS_STORING && !nv_done) |=> !busy_n && !grant);

endmodule

// File: rtl/nvsram_hw_store_ctrl.sv
module nvsram_hw_store_ctrl #(
   parameter int SYNC_STAGES     = 2,
   parameter int MIN_LOW_CYCLES  = 3,
   parameter int DRAIN_CYCLES    = 4,
   parameter int RECOVER_CYCLES  = 5,
   parameter int BUSY_MAX_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic store_req_n,
   input  logic sram_ce_n,
   input  logic sram_we_n,
   input  logic nv_store_done,
   input  logic nv_recall_done,
   output logic nv_store_go,
   output logic busy_n,
   output logic sram_grant
);

   localparam int BUSY_LATENCY = SYNC_STAGES + MIN_LOW_CYCLES + 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (MIN_LOW_CYCLES < 1) begin : g_bad_low
         $error("MIN_LOW_CYCLES must be at least 1");
      end
      if (DRAIN_CYCLES < 1 || RECOVER_CYCLES < 1) begin : g_bad_win
         $error("drain and recovery windows must be at least one cycle");
      end
      if (BUSY_LATENCY > BUSY_MAX_CYCLES) begin : g_bad_busy
         $error("busy latency exceeds BUSY_MAX_CYCLES");
      end
   endgenerate

   logic pin_high, req_seen, dirty, store_complete;
   logic cyc_active, wr_stb;

   assign cyc_active = ~sram_ce_n;
   assign wr_stb     = sram_grant & ~sram_ce_n & ~sram_we_n;

   hsr_req_filter #(
      .SYNC_STAGES   (SYNC_STAGES),
      .MIN_LOW_CYCLES(MIN_LOW_CYCLES)
   ) u_filter (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_n   (store_req_n),
      .pin_high(pin_high),
      .req_seen(req_seen)
   );

   hsr_dirty u_dirty (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_stb(wr_stb),
      .clr   (store_complete | nv_recall_done),
      .dirty (dirty)
   );

   hsr_fsm #(
      .DRAIN_CYCLES  (DRAIN_CYCLES),
      .RECOVER_CYCLES(RECOVER_CYCLES)
   ) u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_seen      (req_seen),
      .pin_high      (pin_high),
      .cyc_active    (cyc_active),
      .dirty         (dirty),
      .nv_done       (nv_store_done),
      .busy_n        (busy_n),
      .grant         (sram_grant),
      .store_go      (nv_store_go),
      .store_complete(store_complete)
   );

   // R5 / R6: a start pulse only when the array holds unsaved writes
   a_r5_go_needs_dirty: assert property (@(posedge clk) disable iff (!rst_n)
      nv_store_go |-> dirty);

   // R7: a strobe arriving without a grant is not counted
   a_r7_no_count_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (!sram_grant && !dirty && !sram_ce_n && !sram_we_n) |=> !dirty);

endmodule

// File: tb/sim_nvsram_hw_store_ctrl.sv
module sim_nvsram_hw_store_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int SYNC   = 2;
   localparam int MINLOW = 3;
   localparam int DRAIN  = 4;
   localparam int RECOV  = 5;
   localparam int BMAX   = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_n = 1'b1, ce_n = 1'b1, we_n = 1'b1;
   logic st_done = 1'b0, rc_done = 1'b0;
   logic go, busy_n, grant;

   int n_cmp = 0, n_bad = 0;
   int cyc = 0, done_cyc = 0, go_cnt = 0, eng_cnt = 0, eng_len = 6;
   bit mdirty = 0, prev_go = 0, ended = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   nvsram_hw_store_ctrl #(
      .SYNC_STAGES(SYNC), .MIN_LOW_CYCLES(MINLOW), .DRAIN_CYCLES(DRAIN),
      .RECOVER_CYCLES(RECOV), .BUSY_MAX_CYCLES(BMAX)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .store_req_n(req_n), .sram_ce_n(ce_n),
      .sram_we_n(we_n), .nv_store_done(st_done), .nv_recall_done(rc_done),
      .nv_store_go(go), .busy_n(busy_n), .sram_grant(grant)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   always @(posedge clk) cyc++;

   // engine stand-in: done a fixed number of cycles after each start pulse
   always @(negedge clk) begin
      st_done = 1'b0;
      if (eng_cnt > 0) begin
         eng_cnt--;
         if (eng_cnt == 0) begin
            st_done  = 1'b1;
            done_cyc = cyc;
         end
      end
      if (go === 1'b1) begin
         go_cnt++;
         chk(!prev_go, "R10 go width", 2, 1);
         eng_cnt = eng_len;
      end
      prev_go = (go === 1'b1);
   end

   initial begin
      #(CLK_PERIOD * 150000);
      chk(0, "watchdog", 0, 1);
      finish_run();
   end

   function automatic bit store_expected(input bit flag);
      return flag;
   endfunction

   task automatic do_write();
      @(negedge clk); ce_n = 1'b0; we_n = 1'b0; mdirty = 1;
      @(negedge clk); ce_n = 1'b1; we_n = 1'b1;
   endtask

   task automatic do_recall(input bit with_write);
      @(negedge clk); rc_done = 1'b1;
      if (with_write) begin ce_n = 1'b0; we_n = 1'b0; end
      @(negedge clk); rc_done = 1'b0; ce_n = 1'b1; we_n = 1'b1;
      mdirty = 0;
   endtask

   task automatic wait_idle(input string req, input int limit, output int m);
      m = 0;
      while (busy_n !== 1'b1 && m < limit) begin @(negedge clk); m++; end
      chk(busy_n === 1'b1 && grant === 1'b1, req, int'(busy_n), 1);
   endtask

   task automatic hw_store(input int low_len, input bit wr_in_busy);
      int g0 = go_cnt;
      bit exp = store_expected(mdirty);
      int k = 0, held = 1, m;
      @(negedge clk); req_n = 1'b0;
      while (busy_n === 1'b1 && k < BMAX + 3) begin @(negedge clk); k++; held++; end
      chk(k <= BMAX, "R3 busy latency", k, BMAX);
      while (held < low_len) begin
         @(negedge clk); held++;
         if (wr_in_busy && held == k + DRAIN + 3) begin
            chk(grant === 1'b0, "R7 grant while busy", int'(grant), 0);
            ce_n = 1'b0; we_n = 1'b0;
         end else begin
            ce_n = 1'b1; we_n = 1'b1;
         end
      end
      @(negedge clk); req_n = 1'b1; ce_n = 1'b1; we_n = 1'b1;
      chk(busy_n === 1'b0 && grant === 1'b0, "R8 inhibit at release", int'(grant), 0);
      wait_idle("R8 returns to idle", 300, m);
      if (exp) chk(cyc - done_cyc >= RECOV, "R8 recovery after done", cyc - done_cyc, RECOV);
      else chk(m >= RECOV && m <= SYNC + RECOV + 2, "R8 recovery after release", m, SYNC + RECOV + 1);
      chk(go_cnt - g0 == int'(exp), exp ? "R5 store started" : "R6 no store", go_cnt - g0, int'(exp));
      if (exp) mdirty = 0;
   endtask

   task automatic short_pulse(input int len);
      @(negedge clk); req_n = 1'b0;
      repeat (len) @(negedge clk);
      req_n = 1'b1;
      for (int i = 0; i < SYNC + MINLOW + 4; i++) begin
         @(negedge clk);
         chk(busy_n === 1'b1 && grant === 1'b1, "R2 short pulse ignored", int'(busy_n), 1);
      end
   endtask

   task automatic exact_pulse();
      int g0 = go_cnt, k = 0, m;
      bit exp = store_expected(mdirty);
      @(negedge clk); req_n = 1'b0;
      repeat (MINLOW) begin
         @(negedge clk); k++;
         if (busy_n === 1'b0) break;
      end
      req_n = 1'b1;
      while (busy_n === 1'b1 && k < BMAX + 3) begin @(negedge clk); k++; end
      chk(k <= BMAX, "R3 minimum pulse recognised", k, BMAX);
      wait_idle("R8 idle after minimum pulse", 300, m);
      chk(go_cnt - g0 == int'(exp), "R5 R6 minimum pulse store", go_cnt - g0, int'(exp));
      if (exp) mdirty = 0;
   endtask

   task automatic drain_test(input int ce_len, input bit is_write, input int exp_g);
      int g0 = go_cnt, gcnt = 0, bad = 0, m;
      bit exp;
      @(negedge clk); ce_n = 1'b0; we_n = !is_write; req_n = 1'b0;
      if (is_write) mdirty = 1;
      exp = store_expected(mdirty);
      for (int i = 1; i <= 30; i++) begin
         @(negedge clk);
         if (busy_n === 1'b0 && grant === 1'b1) begin
            gcnt++;
            if (ce_n) bad++;
         end
         if (i == ce_len) begin ce_n = 1'b1; we_n = 1'b1; end
      end
      chk(gcnt == exp_g, "R4 drain grant cycles", gcnt, exp_g);
      chk(bad == 0, "R4 no grant outside cycle", bad, 0);
      @(negedge clk); ce_n = 1'b1; we_n = 1'b1; req_n = 1'b1;
      wait_idle("R8 idle after drain", 300, m);
      chk(go_cnt - g0 == int'(exp), "R5 store after drain", go_cnt - g0, int'(exp));
      if (exp) mdirty = 0;
   endtask

   initial begin
      void'($urandom(32'h5A17));
      #1;
      chk(busy_n === 1'b1 && grant === 1'b1 && go === 1'b0, "R1 in reset", int'(busy_n), 1);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy_n === 1'b1 && grant === 1'b1 && go === 1'b0, "R1 after reset", int'(grant), 1);

      short_pulse(MINLOW - 1);
      short_pulse(1);
      hw_store(20, 0);               // R6: nothing written since reset
      do_write();
      hw_store(20, 0);               // R5
      hw_store(20, 0);               // R6: flag cleared by the store
      hw_store(24, 1);               // R7: write attempt while inhibited
      hw_store(20, 0);               // R7: that attempt left the flag clear
      do_write();
      eng_len = 40;
      hw_store(10, 0);               // R8: release long before done
      eng_len = 6;
      do_write();
      do_recall(1);                  // R9: clear beats simultaneous write
      hw_store(20, 0);
      drain_test(40, 1, DRAIN);      // R4: cycle outlasts the window
      drain_test(2, 0, 0);           // R4: cycle ends before recognition
      exact_pulse();                 // R3: exactly the minimum

      for (int it = 0; it < 60; it++) begin
         int sel = $urandom_range(0, 4);
         eng_len = $urandom_range(1, 20);
         case (sel)
            0: do_write();
            1: do_recall($urandom_range(0, 1));
            2: short_pulse($urandom_range(1, MINLOW - 1));
            3: hw_store($urandom_range(8, 30), 0);
            default: hw_store($urandom_range(24, 32), $urandom_range(0, 1));
         endcase
         repeat ($urandom_range(1, 3)) @(negedge clk);
      end

      finish_run();
   end

endmodule